// File: doc/BRIEF.md
# Seven-Row Column-Compression Adder

This block adds seven unsigned operands of equal width in one combinational pass. Each bit column is treated as a pile of seven equally weighted bits. A dedicated seven-input counter turns that pile into a three-bit count of its ones. The counts from all columns are then laid out as three rows, each shifted by the weight of its count bit. A three-input row adder combines those rows into the final sum. The result is wide enough that no input combination can overflow it.

Each column counter is split into two smaller counters. A full adder counts three of the inputs, and a four-input counter handles the rest. Their two partial counts are merged by a short adder. That adder forms its upper carry from generate and propagate terms rather than by rippling. The block has no clock and no state. It fits wherever a wide multi-operand sum is needed inside one cycle of a surrounding datapath.

Top module: `col_compress_adder`

## Requirements
- R1: For every column i, the count produced for that column equals the number of ones among bit i of the seven operands, as a 3-bit value from 0 to 7.
- R2: Operands 0, 1 and 2 form the small group; their ones in a column are counted into a 2-bit value from 0 to 3.
- R3: Operands 3 to 6 form the large group; their ones are counted into a 3-bit value in which bit 0 is the parity of the four bits, the value is 3'b010 for exactly two ones, and 3'b100 appears only when all four bits are one.
- R4: A column count is the sum of the two group counts. Bit 0 is their low bits XORed. Bit 1 is the propagate of the high bits XORed with the low-bit generate. Bit 2 is set by the large group's top bit or by the carry G1 | (P1 & G0).
- R5: Count bit j of column i lands in row j at bit position i + j, and every other row bit is zero (row 1 bit 0 and row 2 bits 1:0 are always 0).
- R6: The output equals the exact unsigned sum of the seven operands in N+3 bits; all operands at their maximum give 7*(2^N-1) with no wrap.
- R7: The output depends only on the present inputs: after any input change it settles to the sum of the new operands, with no effect left over from earlier inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op0 | input | N | Operand 0 (small group) |
| op1 | input | N | Operand 1 (small group) |
| op2 | input | N | Operand 2 (small group) |
| op3 | input | N | Operand 3 (large group) |
| op4 | input | N | Operand 4 (large group) |
| op5 | input | N | Operand 5 (large group) |
| op6 | input | N | Operand 6 (large group) |
| sum | output | N+3 | Unsigned sum of all seven operands |

## Verification
The assertions are immediate checks on a purely combinational path. They assume every input is a known 0 or 1 once it settles, and they apply no other restriction: any operand value is legal. The stimulus drives only defined values. It changes them half a clock period before each sample, so every check sees settled logic. The column sweeps place each of the 128 patterns in one column at a time to reach every counter case. Random full-width operands and all-ones operands then exercise the row alignment and the top bits of the sum.

// File: rtl/col_compress_pkg.sv
package col_compress_pkg;

  // count of ones in three bits, full-adder style: {carry, sum}
  function automatic logic [1:0] fa_count(input logic [2:0] b);
    logic s, c;
    s = b[0] ^ b[1] ^ b[2];
    c = (b[0] & b[1]) | (b[2] & (b[0] ^ b[1]));
    return {c, s};
  endfunction

  // count of ones in four bits, built from two bit-pairs
  function automatic logic [2:0] quad_count(input logic [3:0] b);
    logic pl, gl, ph, gh;
    pl = b[0] ^ b[1];
    gl = b[0] & b[1];
    ph = b[2] ^ b[3];
    gh = b[2] & b[3];
    return {gl & gh, gl ^ gh ^ (pl & ph), pl ^ ph};
  endfunction

endpackage

// File: rtl/tri_counter.sv
module tri_counter (
  input  logic [2:0] bits,
  output logic [1:0] cnt
);
  import col_compress_pkg::*;

  always_comb cnt = fa_count(bits);
endmodule

// File: rtl/quad_counter.sv
module quad_counter (
  input  logic [3:0] bits,
  output logic [2:0] cnt
);
  import col_compress_pkg::*;

  always_comb cnt = quad_count(bits);
endmodule

// File: rtl/seven_counter.sv
module seven_counter (
  input  logic [6:0] bits,
  output logic [1:0] qa,
  output logic [2:0] qb,
  output logic [2:0] q
);
  logic g0, p1, g1, c2;

  tri_counter u_small (
    .bits(bits[2:0]),
    .cnt (qa)
  );

  quad_counter u_large (
    .bits(bits[6:3]),
    .cnt (qb)
  );

  // merge the partial counts with generate/propagate terms
  always_comb begin
    g0 = qa[0] & qb[0];
    p1 = qa[1] ^ qb[1];
    g1 = qa[1] & qb[1];
    c2 = g1 | (p1 & g0);
    q  = {qb[2] | c2, p1 ^ g0, qa[0] ^ qb[0]};
  end
endmodule

// File: rtl/row_adder3.sv
module row_adder3 #(
  parameter int W = 10
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W:0]   total
);
  logic [W-1:0] s_row;
  logic [W-1:0] c_row;

  always_comb begin
    s_row = a ^ b ^ c;
    c_row = (a & b) | (c & (a ^ b));
    total = {1'b0, s_row} + {c_row, 1'b0};
  end
endmodule

// File: rtl/col_compress_adder.sv
module col_compress_adder #(
  parameter int N = 8
) (
  input  logic [N-1:0] op0,
  input  logic [N-1:0] op1,
  input  logic [N-1:0] op2,
  input  logic [N-1:0] op3,
  input  logic [N-1:0] op4,
  input  logic [N-1:0] op5,
  input  logic [N-1:0] op6,
  output logic [N+2:0] sum
);
  localparam int RW = N + 2;

  logic [N-1:0][1:0] col_qa;
  logic [N-1:0][2:0] col_qb;
  logic [N-1:0][2:0] col_q;
  logic [RW-1:0] row0, row1, row2;

  for (genvar i = 0; i < N; i++) begin : g_col
    logic [6:0] col_bits;
    assign col_bits = {op6[i], op5[i], op4[i], op3[i], op2[i], op1[i], op0[i]};

    seven_counter u_cnt (
      .bits(col_bits),
      .qa  (col_qa[i]),
      .qb  (col_qb[i]),
      .q   (col_q[i])
    );
  end

  // realign column counts as weighted rows
  always_comb begin
    row0 = '0;
    row1 = '0;
    row2 = '0;
    for (int i = 0; i < N; i++) begin
      row0[i]     = col_q[i][0];
      row1[i + 1] = col_q[i][1];
      row2[i + 2] = col_q[i][2];
    end
  end

  row_adder3 #(.W(RW)) u_rows (
    .a    (row0),
    .b    (row1),
    .c    (row2),
    .total(sum)
  );
endmodule

// File: rtl/col_compress_chk.sv
module col_compress_chk #(
  parameter int N = 8
) (
  input logic [N-1:0]      op0,
  input logic [N-1:0]      op1,
  input logic [N-1:0]      op2,
  input logic [N-1:0]      op3,
  input logic [N-1:0]      op4,
  input logic [N-1:0]      op5,
  input logic [N-1:0]      op6,
  input logic [N-1:0][1:0] col_qa,
  input logic [N-1:0][2:0] col_qb,
  input logic [N-1:0][2:0] col_q,
  input logic [N+1:0]      row0,
  input logic [N+1:0]      row1,
  input logic [N+1:0]      row2,
  input logic [N+2:0]      sum
);
  localparam int SW = N + 3;

  logic [SW-1:0] ref_sum;

  always_comb begin
    ref_sum = SW'(op0) + SW'(op1) + SW'(op2) + SW'(op3)
            + SW'(op4) + SW'(op5) + SW'(op6);
    for (int i = 0; i < N; i++) begin
      logic [6:0] cb;
      cb = {op6[i], op5[i], op4[i], op3[i], op2[i], op1[i], op0[i]};
      assert_col_count_R1: assert (col_q[i] == 3'($countones(cb)))
        else $error("column %0d count wrong", i);
      assert_small_group_R2: assert (col_qa[i] == 2'($countones(cb[2:0])))
        else $error("column %0d small group count wrong", i);
      assert_large_group_R3: assert (col_qb[i] == 3'($countones(cb[6:3])))
        else $error("column %0d large group count wrong", i);
      assert_merge_R4: assert (col_q[i] == 3'(col_qa[i]) + col_qb[i])
        else $error("column %0d merge wrong", i);
      assert_row_place_R5: assert (row0[i] == col_q[i][0] && row1[i + 1] == col_q[i][1]
                                   && row2[i + 2] == col_q[i][2])
        else $error("column %0d row placement wrong", i);
    end
    assert_row_zero_R5: assert (row1[0] == 1'b0 && row2[1:0] == 2'b00
                                && row0[N+1:N] == 2'b00 && row1[N+1] == 1'b0)
      else $error("unused row bits nonzero");
    assert_no_overflow_R6: assert (sum == ref_sum)
      else $error("sum mismatch");
  end
endmodule

bind col_compress_adder col_compress_chk #(.N(N)) u_chk (
  .op0(op0), .op1(op1), .op2(op2), .op3(op3),
  .op4(op4), .op5(op5), .op6(op6),
  .col_qa(col_qa), .col_qb(col_qb), .col_q(col_q),
  .row0(row0), .row1(row1), .row2(row2),
  .sum(sum)
);

// File: tb/col_compress_adder_tb.sv
module col_compress_adder_tb;
  localparam int N  = 8;
  localparam int SW = N + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] op [7];
  logic [SW-1:0] sum;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  col_compress_adder #(.N(N)) u_dut (
    .op0(op[0]), .op1(op[1]), .op2(op[2]), .op3(op[3]),
    .op4(op[4]), .op5(op[5]), .op6(op[6]),
    .sum(sum)
  );

  task automatic check(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at falling edge, sample at next rising edge
  task automatic apply_and_check(input string req);
    logic [SW-1:0] exp;
    exp = '0;
    for (int k = 0; k < 7; k++) exp = exp + SW'(op[k]);
    @(posedge clk);
    #1;
    check(req, sum, exp);
    @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 7; k++) op[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R6 reset-state zero", sum, '0);
    @(negedge clk);

    // R1: exhaustive column patterns, each column in turn
    for (int col = 0; col < N; col++) begin
      for (int pat = 0; pat < 128; pat++) begin
        for (int k = 0; k < 7; k++) op[k] = N'(((pat >> k) & 1) << col);
        apply_and_check("R1 column count");
      end
    end

    // R2: small group only, R3: large group only (column 0)
    for (int pat = 0; pat < 8; pat++) begin
      for (int k = 0; k < 7; k++) op[k] = (k < 3) ? N'((pat >> k) & 1) : '0;
      apply_and_check("R2 small group");
    end
    for (int pat = 0; pat < 16; pat++) begin
      for (int k = 0; k < 7; k++) op[k] = (k >= 3) ? N'((pat >> (k - 3)) & 1) : '0;
      apply_and_check("R3 large group");
    end

    // R4: merge carry cases, qA=3 with qB of 1..4, in top column
    for (int nb = 1; nb <= 4; nb++) begin
      for (int k = 0; k < 7; k++) op[k] = (k < 3 || k < 3 + nb) ? N'(1 << (N - 1)) : '0;
      apply_and_check("R4 merge carry");
    end

    // R5: all-ones columns push counts into every row position
    for (int k = 0; k < 7; k++) op[k] = N'(8'b1010_0101);
    apply_and_check("R5 row alignment");

    // R6: maximum operands
    for (int k = 0; k < 7; k++) op[k] = '1;
    apply_and_check("R6 max no overflow");
    check("R6 max value", sum, SW'(7 * ((1 << N) - 1)));

    // R7: random operands, back to back changes
    for (int t = 0; t < 2000; t++) begin
      for (int k = 0; k < 7; k++) op[k] = N'($urandom);
      apply_and_check("R7 random operands");
    end
    for (int k = 0; k < 7; k++) op[k] = '0;
    apply_and_check("R7 return to zero");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule